// File: doc/BRIEF.md
# Power-Stage Serial Bus Master

This block is the master of a two-wire synchronous serial bus that connects a controller to several remote power-stage devices. It drives a bus clock and a data line that both sides share, and it performs single-register reads and writes of 8-bit registers inside those devices. The host side asks for one transaction at a time. It holds a request until it receives a one-cycle completion pulse, which carries the read data and an acknowledge-failure indication.

When no host request is waiting, the block runs polls on its own. Each poll reads one fixed fault register, taking the devices in turn. Each value that is read is stored in a local shadow byte for that device. If a device fails to acknowledge, the block sets a sticky error flag for that device and leaves its shadow byte unchanged. A host request waits only for the transaction in flight to finish, and then it takes the bus ahead of the next poll.

The bus clock comes from the system clock through a programmable divider. A divider value `d` gives a bit period of `2*(d+1)` system clocks. The bus clock is low for the first half of each bit and high for the second half.

Top module: `psbus_master`

## Requirements
- R1: While reset is held, the bus clock is high, the data line is released (`sda_oe`=0), `host_done` is 0, every shadow byte is 0 and every error flag is 0.
- R2: Every bit slot lasts `2*(clk_div+1)` system clocks, with the bus clock low for the first half and high for the second half. The master changes its data at the start of a slot. Both sides sample at the rising edge of the bus clock.
- R3: A write frame has these slots in this order: a start slot driven 0; an address byte `{device, register}`, sent MSB first, with the device index in the upper `$clog2(N_DEV)` bits; a direction slot (1 = read, 0 = write); a dead slot; an acknowledge slot (0 = acknowledged); the data byte, MSB first; a dead slot; a second acknowledge slot; a stop slot driven 1. That is 23 slots.
- R4: A read frame has the same start, address, direction, dead and acknowledge slots. The slave then drives the data byte, MSB first, which is followed by a dead slot and a stop slot, 22 slots in all. The byte that was read is presented on `host_rdata`.
- R5: The master releases the data line during dead slots, acknowledge slots and slave-driven data slots.
- R6: `host_done` pulses for one cycle, right after the edge that ends the stop slot of a host frame.
- R7: If the first acknowledge slot samples 1, the frame goes straight to the stop slot (13 slots in all). In that case `host_nack` is 1 and the device's sticky error flag is set.
- R8: Background polls read the fault register (address `FAULT_REG`) of devices 0, 1, … N_DEV-1 in rotation. Each acknowledged poll copies the byte into that device's shadow byte, at bits `[8*d+7:8*d]`.
- R9: An unacknowledged poll leaves the shadow byte unchanged and sets the device's error flag. Error flags are cleared only by reset.
- R10: A pending host request is served by the next frame after the one in progress, and a poll that has begun always completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_div | input | DIV_W | Bus clock divider, bit period = 2*(clk_div+1) |
| host_req | input | 1 | Host request, held until host_done |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 8 | {device, register} address byte |
| host_wdata | input | 8 | Write data |
| host_done | output | 1 | One-cycle completion pulse |
| host_nack | output | 1 | Acknowledge failure of the completed host frame |
| host_rdata | output | 8 | Read data of the completed host frame |
| sclk | output | 1 | Bus clock |
| sda_out | output | 1 | Data line value driven by the master |
| sda_oe | output | 1 | Master drives the data line when 1 |
| sda_in | input | 1 | Data line as seen on the bus |
| fault_shadow | output | 8*N_DEV | Shadow copies of the remote fault registers |
| dev_err | output | N_DEV | Sticky per-device acknowledge-failure flags |

## Verification
Take a host frame whose start slot begins at edge A. Its `host_done` appears after edge A plus the slot count (23, 22 or 13) times `2*(clk_div+1)`. The bench timestamps the bus-clock rise of the start slot and checks that `host_done` is seen exactly slots·P − P/2 cycles later, so it checks both the divider and the frame length. Shadow bytes and error flags follow a full polling round. The bench therefore checks them only after a quiet wait that is longer than one round at the current divider. Line release and the stop level are checked at each rising edge of the bus clock in the affected slot.

// File: rtl/psbus_master.sv
module psbus_master #(
  parameter int N_DEV     = 4,
  parameter int DIV_W     = 4,
  parameter int FAULT_REG = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DIV_W-1:0]   clk_div,
  input  logic               host_req,
  input  logic               host_wr,
  input  logic [7:0]         host_addr,
  input  logic [7:0]         host_wdata,
  output logic               host_done,
  output logic               host_nack,
  output logic [7:0]         host_rdata,
  output logic               sclk,
  output logic               sda_out,
  output logic               sda_oe,
  input  logic               sda_in,
  output logic [8*N_DEV-1:0] fault_shadow,
  output logic [N_DEV-1:0]   dev_err
);
  localparam int DEV_W = (N_DEV > 1) ? $clog2(N_DEV) : 1;
  localparam int REG_W = 8 - DEV_W;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDR, S_RW, S_DEAD1, S_ACK1, S_DATA, S_DEAD2, S_ACK2, S_STOP
  } st_t;

  st_t              st;
  logic [DIV_W-1:0] cnt;
  logic             phase, samp, cur_wr, cur_host, nack;
  logic [2:0]       bitn;
  logic [7:0]       shreg, wbyte;
  logic [DEV_W-1:0] cur_dev, poll_dev;

  wire tick    = (cnt >= clk_div);
  wire mid     = (st != S_IDLE) && tick && !phase;
  wire bit_end = (st != S_IDLE) && tick && phase;
  wire fin     = bit_end && (st == S_STOP);

  assign sda_oe  = (st == S_START) || (st == S_ADDR) || (st == S_RW) ||
                   (st == S_STOP) || ((st == S_DATA) && cur_wr);
  assign sda_out = (st == S_STOP) ? 1'b1 :
                   (st == S_RW)   ? ~cur_wr :
                   ((st == S_ADDR) || (st == S_DATA)) ? shreg[7] : 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; cnt <= '0; phase <= 1'b0; samp <= 1'b1; sclk <= 1'b1;
      cur_wr <= 1'b0; cur_host <= 1'b0; nack <= 1'b0; bitn <= '0;
      shreg <= '0; wbyte <= '0; cur_dev <= '0; poll_dev <= '0;
      host_done <= 1'b0; host_nack <= 1'b0; host_rdata <= '0;
      fault_shadow <= '0; dev_err <= '0;
    end else begin
      host_done <= 1'b0;
      if (st == S_IDLE) begin
        cnt <= '0; phase <= 1'b0; nack <= 1'b0; sclk <= 1'b0; st <= S_START;
        if (host_req) begin
          cur_host <= 1'b1; cur_wr <= host_wr; shreg <= host_addr;
          wbyte <= host_wdata; cur_dev <= host_addr[7 -: DEV_W];
        end else begin
          cur_host <= 1'b0; cur_wr <= 1'b0; cur_dev <= poll_dev;
          shreg <= {poll_dev, FAULT_REG[REG_W-1:0]};
        end
      end else begin
        cnt <= tick ? '0 : cnt + 1'b1;
        if (tick) phase <= ~phase;
        if (mid) begin
          samp <= sda_in;
          sclk <= 1'b1;
        end
        if (bit_end) begin
          sclk <= (st == S_STOP);
          case (st)
            S_START: begin st <= S_ADDR; bitn <= 3'd7; end
            S_ADDR: begin
              shreg <= {shreg[6:0], 1'b0};
              if (bitn == 3'd0) st <= S_RW; else bitn <= bitn - 3'd1;
            end
            S_RW:    st <= S_DEAD1;
            S_DEAD1: st <= S_ACK1;
            S_ACK1: begin
              if (samp) begin
                nack <= 1'b1; st <= S_STOP;
              end else begin
                st <= S_DATA; bitn <= 3'd7;
                if (cur_wr) shreg <= wbyte;
              end
            end
            S_DATA: begin
              shreg <= {shreg[6:0], cur_wr ? 1'b0 : samp};
              if (bitn == 3'd0) st <= S_DEAD2; else bitn <= bitn - 3'd1;
            end
            S_DEAD2: st <= cur_wr ? S_ACK2 : S_STOP;
            S_ACK2: begin
              if (samp) nack <= 1'b1;
              st <= S_STOP;
            end
            default: begin
              st <= S_IDLE;
              if (cur_host) begin
                host_done <= 1'b1; host_nack <= nack; host_rdata <= shreg;
              end else begin
                poll_dev <= (poll_dev == DEV_W'(N_DEV - 1)) ? '0 : poll_dev + 1'b1;
                if (!nack) fault_shadow[{cur_dev, 3'b000} +: 8] <= shreg;
              end
              if (nack) dev_err[cur_dev] <= 1'b1;
            end
          endcase
        end
      end
    end
  end

  AST_SCLK_HIGH_IDLE: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE) |-> sclk); // R1
  AST_RELEASE_SLAVE_SLOTS: assert property (@(posedge clk) disable iff (rst)
    ((st == S_DEAD1) || (st == S_DEAD2) || (st == S_ACK1) || (st == S_ACK2)) |-> !sda_oe); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    host_done |=> !host_done); // R6
  AST_NACK_TO_STOP: assert property (@(posedge clk) disable iff (rst)
    (bit_end && (st == S_ACK1) && samp) |=> (st == S_STOP)); // R7
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(fin && !cur_host && !nack) |=> $stable(fault_shadow)); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((dev_err & $past(dev_err)) == $past(dev_err))); // R9
  AST_HOST_FIRST: assert property (@(posedge clk) disable iff (rst)
    ((st == S_IDLE) && host_req) |=> cur_host); // R10
endmodule

// File: tb/psbus_master_bench.sv
module psbus_master_bench;
  localparam int ND = 4;
  localparam int FREG = 5;

  logic clk = 1'b0, rst = 1'b1;
  logic [3:0] clk_div = 4'd1;
  logic host_req = 1'b0, host_wr = 1'b0;
  logic [7:0] host_addr = '0, host_wdata = '0;
  logic host_done, host_nack, sclk, sda_out, sda_oe, sda_in;
  logic [7:0] host_rdata;
  logic [8*ND-1:0] fault_shadow;
  logic [ND-1:0] dev_err;

  always #2.5 clk = ~clk;

  psbus_master #(.N_DEV(ND), .DIV_W(4), .FAULT_REG(FREG)) u_psbus_master (
    .clk(clk), .rst(rst), .clk_div(clk_div), .host_req(host_req), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_done(host_done),
    .host_nack(host_nack), .host_rdata(host_rdata), .sclk(sclk), .sda_out(sda_out),
    .sda_oe(sda_oe), .sda_in(sda_in), .fault_shadow(fault_shadow), .dev_err(dev_err));

  int vectors = 0, miscompares = 0, cyc = 0, start_cyc = 0, frames = 0;
  logic [7:0] smem [ND][64];
  logic [7:0] mir  [ND][64];
  bit present [ND];
  bit ever_absent [ND];
  int gen = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] init_val(int d, int r);
    return 8'(d * 37 + r * 11 + 5);
  endfunction
  function automatic logic [7:0] fval(int d, int g);
    return 8'(8'h21 + d * 19 + g * 68);
  endfunction
  function automatic int period();
    return 2 * (int'(clk_div) + 1);
  endfunction

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 190000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  // slave model on the shared line
  int spos = -1;
  logic [7:0] s_addr = '0, s_data = '0;
  logic s_rd = 1'b0, s_pres = 1'b0, s_drv = 1'b0, s_val = 1'b1;
  assign sda_in = sda_oe ? sda_out : (s_drv ? s_val : 1'b1);

  always @(posedge sclk) begin
    if (spos < 0) begin
      if (sda_oe && !sda_out) begin
        spos = 0; start_cyc = cyc; frames++;
      end
    end else begin
      int endp;
      spos++;
      if (spos >= 1 && spos <= 8) s_addr = {s_addr[6:0], sda_out};
      else if (spos == 9) begin
        s_rd = sda_out;
        s_pres = present[int'(s_addr[7:6])];
      end
      endp = !s_pres ? 12 : (s_rd ? 21 : 22);
      if (spos == endp) begin
        chk(sda_oe && sda_out, "R3", "stop slot driven high", int'(sda_oe && sda_out), 1);
        if (s_pres && !s_rd) smem[int'(s_addr[7:6])][int'(s_addr[5:0])] = s_data;
        spos = -1;
      end else if (spos == 10 || spos == 11 || spos == 20 || (spos == 21 && !s_rd)) begin
        chk(!sda_oe, "R5", "released in dead/ack slot", int'(sda_oe), 0);
      end else if (spos >= 12 && spos <= 19) begin
        if (s_rd) chk(!sda_oe, "R5", "released in slave data slot", int'(sda_oe), 0);
        else s_data = {s_data[6:0], sda_out};
      end
    end
  end

  always @(negedge sclk) begin
    int nx;
    s_drv = 1'b0; s_val = 1'b1;
    if (spos >= 0) begin
      nx = spos + 1;
      if (s_pres && (nx == 11 || (nx == 21 && !s_rd))) begin
        s_drv = 1'b1; s_val = 1'b0;
      end else if (s_pres && s_rd && nx >= 12 && nx <= 19) begin
        s_drv = 1'b1;
        s_val = smem[int'(s_addr[7:6])][int'(s_addr[5:0])][19 - nx];
      end
    end
  end

  task automatic run_op(bit we, int dev, int rg, logic [7:0] wd, logic [3:0] dv);
    int lat = 0, f0, bits, p;
    bit got = 0, en;
    @(negedge clk);
    clk_div = dv; host_req = 1'b1; host_wr = we;
    host_addr = {2'(dev), 6'(rg)}; host_wdata = wd; f0 = frames;
    while (!got && lat < 6000) begin
      @(negedge clk); lat++;
      if (host_done) got = 1;
    end
    host_req = 1'b0;
    p = period();
    en = !present[dev];
    bits = en ? 13 : (we ? 23 : 22);
    chk(got, "R6", "host_done pulse seen", int'(got), 1);
    chk(cyc - start_cyc == bits * p - p / 2, "R2", "frame length in cycles",
        cyc - start_cyc, bits * p - p / 2);
    chk(frames == f0 + 1 || frames == f0 + 2, "R10", "host frame next after current",
        frames - f0, 2);
    chk(host_nack == en, "R7", "host_nack", int'(host_nack), int'(en));
    if (en) chk(dev_err[dev], "R7", "error flag after nack", int'(dev_err[dev]), 1);
    else if (we) mir[dev][rg] = wd;
    else chk(host_rdata == mir[dev][rg], "R4", "read data", int'(host_rdata), int'(mir[dev][rg]));
  endtask

  task automatic check_poll(string tag);
    for (int d = 0; d < ND; d++) begin
      logic [7:0] es;
      es = present[d] ? fval(d, gen) : 8'h00;
      chk(fault_shadow[8*d +: 8] == es, "R8", {tag, " shadow byte"},
          int'(fault_shadow[8*d +: 8]), int'(es));
      chk(dev_err[d] == ever_absent[d], "R9", {tag, " error flag"},
          int'(dev_err[d]), int'(ever_absent[d]));
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int d = 0; d < ND; d++) begin
      present[d] = (d != 3);
      ever_absent[d] = (d == 3);
      for (int r = 0; r < 64; r++) begin
        smem[d][r] = init_val(d, r);
        mir[d][r]  = init_val(d, r);
      end
      smem[d][FREG] = fval(d, 0);
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(sclk, "R1", "bus clock high in reset", int'(sclk), 1);
    chk(!sda_oe, "R1", "line released in reset", int'(sda_oe), 0);
    chk(!host_done, "R1", "no done in reset", int'(host_done), 0);
    chk(fault_shadow == '0, "R1", "shadows zero in reset", int'(fault_shadow[7:0]), 0);
    chk(dev_err == '0, "R1", "error flags zero in reset", int'(dev_err), 0);
    rst = 1'b0;
    repeat (3000) @(negedge clk);
    check_poll("first round");

    run_op(1, 0, 10, 8'hA5, 4'd1);
    run_op(0, 0, 10, 8'h00, 4'd1);
    run_op(1, 2, 63, 8'h5A, 4'd0);
    run_op(0, 2, 63, 8'h00, 4'd0);
    run_op(1, 3, 7, 8'hFF, 4'd1);
    run_op(0, 3, 7, 8'h00, 4'd1);
    run_op(0, 1, 0, 8'h00, 4'd15);
    run_op(1, 1, 33, 8'h81, 4'd15);

    for (int i = 0; i < 40; i++) begin
      int dev, rg;
      dev = int'($urandom % ND);
      rg  = int'($urandom % 64);
      if (rg == FREG) rg = FREG + 1;
      run_op(1'($urandom % 2), dev, rg, 8'($urandom), 4'($urandom % 3));
    end

    @(negedge clk);
    clk_div = 4'd1;
    present[3] = 1'b1;
    gen = 1;
    for (int d = 0; d < ND; d++) smem[d][FREG] = fval(d, 1);
    repeat (4000) @(negedge clk);
    check_poll("after recovery");
    run_op(0, 3, 12, 8'h00, 4'd1);
    chk(dev_err[3], "R9", "flag still set after recovery", int'(dev_err[3]), 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule